// File: doc/BRIEF.md
# Quadrature Position Counter with Buffered Capture

This block turns the two phase-shifted channels of an incremental encoder into a signed position held in a wrapping up/down counter. A two-bit mode input selects the decoding resolution: one count per quadrature cycle, two counts per cycle (edges of channel A only), or four counts per cycle (every edge of either channel). The count direction follows the phase relation of the channels. When channel A leads channel B, the count goes up. When B leads A, it goes down.

A separate sample line captures position. Each rising edge of that line copies the current count into a small first-in first-out store. The consumer drains the store through a show-ahead read port with a pop strobe. An edge that arrives when the store is full is discarded and raises a sticky overflow flag. If both channels change in the same clock, the step cannot be decoded. The count is then left alone and a sticky error flag is raised. Counting, capture and error detection only take place while the arm input is high. The channel and sample inputs must already be synchronous to the clock.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count is 0, the store is empty (fifo_valid 0, fifo_full 0), and overflow and trans_err are 0.
- R2: With mode 2 or 3 (four-edge decoding), every clock in which exactly one of chan_a or chan_b changes moves the count by one. The state sequence {A,B} 00, 10, 11, 01, 00 counts up, and the reverse sequence counts down.
- R3: With mode 1 (two-edge decoding), only changes of chan_a move the count. The count goes up when the new A differs from B and down when it equals B. Changes of chan_b alone leave the count unchanged.
- R4: With mode 0 (one-edge decoding), the count goes up on a rise of chan_a while chan_b is 0, and down on a fall of chan_a while chan_b is 0. All other transitions leave the count unchanged.
- R5: While arm is 0, the count does not change, no sample is stored and trans_err is not set, whatever the channel and sample inputs do.
- R6: A clock in which chan_a and chan_b both change, while armed, leaves the count unchanged and sets trans_err. trans_err stays set until err_clr is pulsed, and a new illegal step takes priority over a clear in the same cycle.
- R7: The count wraps modulo 2^CNT_W. One down step from 0 gives all ones, and one up step from all ones gives 0.
- R8: A rising edge of smp_clk while armed stores the count shown in that same cycle. A line that is held high stores only once. Entries are read oldest first: fifo_data shows the oldest entry whenever fifo_valid is 1, and fifo_pop removes it. fifo_full is 1 when FIFO_DEPTH entries are held.
- R9: A sample edge that arrives while the store is full is dropped, leaving the stored entries intact, and sets overflow. overflow stays set until ovf_clr is pulsed, and a new drop takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables counting, capture and error detection |
| mode | input | 2 | Decoding resolution: 0 one-edge, 1 two-edge, 2 or 3 four-edge |
| chan_a | input | 1 | Encoder channel A, synchronous to clk |
| chan_b | input | 1 | Encoder channel B, synchronous to clk |
| smp_clk | input | 1 | Sample line; a rising edge captures the count |
| fifo_pop | input | 1 | Removes the oldest stored sample |
| err_clr | input | 1 | Clears trans_err |
| ovf_clr | input | 1 | Clears overflow |
| count | output | CNT_W | Current position |
| fifo_data | output | CNT_W | Oldest stored sample |
| fifo_valid | output | 1 | Store holds at least one sample |
| fifo_full | output | 1 | Store holds FIFO_DEPTH samples |
| overflow | output | 1 | Sticky flag: a sample was dropped |
| trans_err | output | 1 | Sticky flag: both channels changed in one clock |

## Verification
The assertions assume that chan_a, chan_b and smp_clk are already synchronous to clk and change at most once per clock. They judge edges by comparing each line with its value one clock earlier. They also assume that the channel lines hold steady across reset release, because the first clock after reset only records the channel levels. The bench drives every input on the falling clock edge. It holds the channels at zero through reset. It raises both channels in one clock only in the scenario that checks the error path.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [1:0]       mode,
  input  logic             chan_a,
  input  logic             chan_b,
  input  logic             smp_clk,
  input  logic             fifo_pop,
  input  logic             err_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] fifo_data,
  output logic             fifo_valid,
  output logic             fifo_full,
  output logic             overflow,
  output logic             trans_err
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic a_q, b_q, smp_q, primed;
  logic step_up, step_dn;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W:0] wr_ptr, rd_ptr;

  wire live    = primed & arm;
  wire a_chg   = chan_a ^ a_q;
  wire b_chg   = chan_b ^ b_q;
  wire illegal = live & a_chg & b_chg;
  wire a_up    = chan_a ^ chan_b;
  wire b_up    = ~(chan_a ^ chan_b);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    if (live && !(a_chg && b_chg)) begin
      case (mode)
        2'd0: if (a_chg && !chan_b) begin
          step_up = chan_a;
          step_dn = ~chan_a;
        end
        2'd1: if (a_chg) begin
          step_up = a_up;
          step_dn = ~a_up;
        end
        default: if (a_chg) begin
          step_up = a_up;
          step_dn = ~a_up;
        end else if (b_chg) begin
          step_up = b_up;
          step_dn = ~b_up;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      smp_q  <= 1'b0;
      primed <= 1'b0;
      cnt_q  <= '0;
    end else begin
      a_q    <= chan_a;
      b_q    <= chan_b;
      smp_q  <= smp_clk;
      primed <= 1'b1;
      if (step_up)      cnt_q <= cnt_q + 1'b1;
      else if (step_dn) cnt_q <= cnt_q - 1'b1;
    end
  end

  wire empty    = (wr_ptr == rd_ptr);
  wire full     = (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]) && (wr_ptr[PTR_W] != rd_ptr[PTR_W]);
  wire push_req = live & smp_clk & ~smp_q;
  wire do_push  = push_req & ~full;
  wire do_pop   = fifo_pop & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      overflow  <= 1'b0;
      trans_err <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push_req && full) overflow <= 1'b1;
      else if (ovf_clr)     overflow <= 1'b0;
      if (illegal)          trans_err <= 1'b1;
      else if (err_clr)     trans_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[PTR_W-1:0]] <= cnt_q;
  end

  assign count      = cnt_q;
  assign fifo_data  = mem[rd_ptr[PTR_W-1:0]];
  assign fifo_valid = ~empty;
  assign fifo_full  = full;
endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [1:0]       mode,
  input logic             chan_a,
  input logic             chan_b,
  input logic             smp_clk,
  input logic             fifo_pop,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             fifo_valid,
  input logic             fifo_full,
  input logic             overflow,
  input logic             trans_err
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic pa, pb, ps, started;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa <= 1'b0; pb <= 1'b0; ps <= 1'b0; started <= 1'b0;
    end else begin
      pa <= chan_a; pb <= chan_b; ps <= smp_clk; started <= 1'b1;
    end
  end

  wire ca = chan_a ^ pa;
  wire cb = chan_b ^ pb;

  assert_hold_disarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(count));

  assert_illegal_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && arm && ca && cb) |=> ($stable(count) && trans_err));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE));

  assert_x1_ignores_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd0 && cb && !ca) |=> $stable(count));

  assert_x2_ignores_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd1 && cb && !ca) |=> $stable(count));

  assert_full_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> fifo_valid);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (started && arm && smp_clk && !ps && fifo_full && !fifo_pop) |=> (overflow && fifo_full));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);
endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .chan_a(chan_a), .chan_b(chan_b),
  .smp_clk(smp_clk), .fifo_pop(fifo_pop), .ovf_clr(ovf_clr), .count(count),
  .fifo_valid(fifo_valid), .fifo_full(fifo_full), .overflow(overflow), .trans_err(trans_err)
);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [1:0] mode = 2'd2;
  logic chan_a = 1'b0, chan_b = 1'b0, smp_clk = 1'b0;
  logic fifo_pop = 1'b0, err_clr = 1'b0, ovf_clr = 1'b0;
  logic [CNT_W-1:0] count, fifo_data;
  logic fifo_valid, fifo_full, overflow, trans_err;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pos_counter #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .chan_a(chan_a), .chan_b(chan_b),
    .smp_clk(smp_clk), .fifo_pop(fifo_pop), .err_clr(err_clr), .ovf_clr(ovf_clr),
    .count(count), .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_full(fifo_full),
    .overflow(overflow), .trans_err(trans_err));

  task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b);
    chan_a = a; chan_b = b;
    @(negedge clk);
  endtask

  task automatic sample();
    smp_clk = 1'b1; @(negedge clk);
    smp_clk = 1'b0; @(negedge clk);
  endtask

  task automatic pop_expect(input logic [CNT_W-1:0] exp);
    check("R8 pop data", fifo_data, exp);
    fifo_pop = 1'b1; @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 valid", 32'(fifo_valid), 0);
    check("R1 full", 32'(fifo_full), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 trans_err", 32'(trans_err), 0);
  endtask

  task automatic t_x4();
    arm = 1'b1; mode = 2'd2;
    drive(1,0); check("R2 up1", count, 1);
    drive(1,1); check("R2 up2", count, 2);
    drive(0,1); check("R2 up3", count, 3);
    drive(0,0); check("R2 up4", count, 4);
    drive(0,1); check("R2 dn1", count, 3);
    drive(1,1); check("R2 dn2", count, 2);
    drive(1,0); check("R2 dn3", count, 1);
    drive(0,0); check("R2 dn4", count, 0);
    mode = 2'd3;
    drive(1,0); check("R2 mode3 up", count, 1);
    drive(0,0); check("R2 mode3 dn", count, 0);
  endtask

  task automatic t_x2();
    mode = 2'd1;
    drive(1,0); check("R3 A rise B0", count, 1);
    drive(1,1); check("R3 B only", count, 1);
    drive(0,1); check("R3 A fall B1", count, 2);
    drive(0,0); check("R3 B only", count, 2);
    drive(0,1); check("R3 B only rev", count, 2);
    drive(1,1); check("R3 A rise B1", count, 1);
    drive(1,0); check("R3 B only rev", count, 1);
    drive(0,0); check("R3 A fall B0", count, 0);
  endtask

  task automatic t_x1();
    mode = 2'd0;
    drive(1,0); check("R4 fwd rise", count, 1);
    drive(1,1); drive(0,1); drive(0,0);
    check("R4 fwd rest", count, 1);
    drive(0,1); drive(1,1); drive(1,0);
    check("R4 rev rest", count, 1);
    drive(0,0); check("R4 rev fall", count, 0);
  endtask

  task automatic t_disarm();
    mode = 2'd2; arm = 1'b0;
    drive(1,0); check("R5 no count", count, 0);
    drive(0,1); check("R5 no err", 32'(trans_err), 0);
    drive(0,0);
    sample(); check("R5 no sample", 32'(fifo_valid), 0);
    arm = 1'b1;
    drive(0,0); check("R5 rearm quiet", count, 0);
  endtask

  task automatic t_wrap();
    mode = 2'd2;
    drive(0,1); check("R7 down wrap", count, 32'hFFFF_FFFF);
    drive(0,0); check("R7 up wrap", count, 0);
  endtask

  task automatic t_illegal();
    drive(1,1); check("R6 count held", count, 0);
    check("R6 err set", 32'(trans_err), 1);
    drive(1,1); check("R6 err sticky", 32'(trans_err), 1);
    err_clr = 1'b1; chan_a = 1'b0; chan_b = 1'b0; @(negedge clk);
    err_clr = 1'b0;
    check("R6 set beats clear", 32'(trans_err), 1);
    check("R6 count held again", count, 0);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check("R6 cleared", 32'(trans_err), 0);
  endtask

  task automatic t_fifo();
    mode = 2'd2;
    sample(); check("R8 one entry", 32'(fifo_valid), 1);
    drive(1,0); sample();
    drive(1,1);
    smp_clk = 1'b1; @(negedge clk); @(negedge clk); @(negedge clk);
    smp_clk = 1'b0; @(negedge clk);
    check("R8 held line once", 32'(fifo_full), 0);
    drive(0,1); sample();
    check("R8 full", 32'(fifo_full), 1);
    drive(0,0); sample();
    check("R9 overflow", 32'(overflow), 1);
    check("R9 still full", 32'(fifo_full), 1);
    pop_expect(0); pop_expect(1); pop_expect(2); pop_expect(3);
    check("R8 drained", 32'(fifo_valid), 0);
    check("R9 sticky", 32'(overflow), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R9 cleared", 32'(overflow), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_x4();
    t_x2();
    t_x1();
    t_disarm();
    t_wrap();
    t_illegal();
    t_fifo();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule